// File: doc/BRIEF.md
# HDB3 Line Codec

This block turns a serial binary stream into the three-level symbol stream carried on an E1 line, and includes the matching receiver-side decoder so the line can be looped back and checked. The transmit side accepts one data bit on each clock where `bit_en` is high. It drives two registered rails: one marks a positive pulse and the other a negative pulse. Ones become pulses of alternating polarity. Any run of four zeros is replaced by a pattern containing a deliberate polarity violation, so the line never goes quiet for long enough to lose timing.

The transmitter chooses between two substitution patterns. If an odd number of pulses has been sent since the previous violation, it uses zero-zero-zero-V. If the count is even, it uses B-zero-zero-V, where B is a balancing pulse. This choice keeps successive violations alternating in polarity, so the line stays DC balanced. The balancing pulse must be placed before the run is known to be complete, so the transmitter holds four bits in flight. Each bit therefore leaves exactly four enables after it entered.

The receive side takes rail pairs on its own enable. It removes substitutions, producing data bits four enables later. It also raises a one-cycle error flag for any pulse pattern that a correct transmitter could not produce.

Top module: `hdb3_line_codec`

## Requirements
- R1: Every output of both sides is registered and changes only on a clock edge where that side's enable is high. On all other edges it holds its value.
- R2: A positive pulse is `pos_out`=1 with `neg_out`=0, and a negative pulse is the reverse. A zero symbol has both rails low, and both rails are never high together.
- R3: After reset, the transmitter's four-slot buffer holds idle zeros, and the symbol emitted on enable k carries the bit that entered on enable k-4. The three idle zeros nearest the data can join a zero run with the first data bits.
- R4: Apart from the four idle symbols right after reset, the line never carries more than three zero symbols in a row.
- R5: Each one is sent as a pulse of the polarity opposite to the previous pulse, and the first pulse after reset is positive. A balancing pulse counts as a previous pulse.
- R6: A run of four zeros that follows an even number of pulses since the last violation is sent as B00V. Reset counts as zero pulses. B takes the polarity opposite to the previous pulse, and V repeats B's polarity.
- R7: A run of four zeros that follows an odd number of pulses since the last violation is sent as 000V, where V repeats the previous pulse's polarity.
- R8: Successive violation pulses have opposite polarities, and the first one after reset is positive.
- R9: The decoder emits on `dec_bit` the bit for the symbol received four enables earlier. A normal pulse decodes as 1, a zero decodes as 0, and a violation decodes as 0 and also forces the three symbols before it to 0. Looped back, the data reappears eight enables after it entered, preceded by eight zeros.
- R10: A pulse that repeats the previous pulse's polarity is a violation only if at least two zero symbols precede it. `dec_err` is high for one cycle after an enable that received any of the following: both rails high; a repeated polarity without those two zeros (decoded as 1); or a violation with the same polarity as the previous violation (the first violation must be positive). `dec_err` is low at all other times.
- R11: While reset is high, all four outputs go low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Transmit bit strobe |
| bit_in | input | 1 | Transmit data bit |
| pos_out | output | 1 | Positive pulse rail |
| neg_out | output | 1 | Negative pulse rail |
| dec_en | input | 1 | Receive symbol strobe |
| dec_p | input | 1 | Received positive rail |
| dec_n | input | 1 | Received negative rail |
| dec_bit | output | 1 | Decoded data bit |
| dec_err | output | 1 | Code violation flag |

## Verification
A wrong pulse-parity state does not show until the next four-zero run. At that point the wrong substitution shape appears, and one violation later two violations arrive with the same polarity. A wrong last-polarity register shows on the very next pulse as a polarity error. A slip in the buffer shifts every symbol and appears four enables after the faulty entry. On the receive side, a wrong gap count or a wrong last-violation register raises `dec_err` on traffic that is valid or misses it on a bad pulse. A violation that fails to clear the preceding symbols lets a balancing pulse out as a spurious one four enables later.

// File: rtl/hdb3_pkg.sv
`timescale 1ns/1ps
package hdb3_pkg;
  // Kind of symbol sitting in a transmit buffer slot.
  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_MARK = 2'd1,
    SYM_BAL  = 2'd2,
    SYM_VIOL = 2'd3
  } sym_kind_e;
endpackage

// File: rtl/hdb3_subst_buf.sv
`timescale 1ns/1ps
// Holds RUN_LEN bits in flight and rewrites a full zero run in place.
module hdb3_subst_buf
  import hdb3_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      din,
  output sym_kind_e head
);
  localparam int LAST = RUN_LEN - 1;

  sym_kind_e slot_q [RUN_LEN];
  logic      pulses_odd_q;   // parity of pulses since the last violation
  logic      run_full;

  // The newest RUN_LEN-1 slots plus the incoming bit form the zero window.
  always_comb begin
    run_full = ~din;
    for (int i = 0; i < LAST; i++) begin
      if (slot_q[i] != SYM_ZERO) run_full = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RUN_LEN; i++) slot_q[i] <= SYM_ZERO;
      pulses_odd_q <= 1'b0;
    end else if (en) begin
      for (int i = 1; i < RUN_LEN; i++) slot_q[i] <= slot_q[i-1];
      if (run_full) begin
        slot_q[0] <= SYM_VIOL;
        if (!pulses_odd_q) slot_q[LAST] <= SYM_BAL;
        pulses_odd_q <= 1'b0;
      end else begin
        slot_q[0] <= din ? SYM_MARK : SYM_ZERO;
        if (din) pulses_odd_q <= ~pulses_odd_q;
      end
    end
  end

  assign head = slot_q[LAST];
endmodule

// File: rtl/hdb3_pulse_drv.sv
`timescale 1ns/1ps
// Assigns polarity to the symbol leaving the buffer and registers the rails.
module hdb3_pulse_drv
  import hdb3_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  sym_kind_e kind,
  output logic      pos_q,
  output logic      neg_q
);
  localparam int CW = $clog2(RUN_LEN + 1) + 1;

  logic last_pos_q;   // 1: previous pulse was positive

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= 1'b0;
      neg_q      <= 1'b0;
      last_pos_q <= 1'b0;
    end else if (en) begin
      unique case (kind)
        SYM_ZERO: begin
          pos_q <= 1'b0;
          neg_q <= 1'b0;
        end
        SYM_MARK, SYM_BAL: begin
          pos_q      <= ~last_pos_q;
          neg_q      <= last_pos_q;
          last_pos_q <= ~last_pos_q;
        end
        SYM_VIOL: begin
          pos_q <= last_pos_q;
          neg_q <= ~last_pos_q;
        end
        default: begin
          pos_q <= 1'b0;
          neg_q <= 1'b0;
        end
      endcase
    end
  end

  // Observation state for the checks below.
  logic [CW-1:0] fill_q;
  logic [CW-1:0] zrun_q;
  logic          vpos_q;   // polarity of last violation, reset negative

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
      zrun_q <= '0;
      vpos_q <= 1'b0;
    end else if (en) begin
      if (fill_q != CW'(RUN_LEN)) fill_q <= fill_q + 1'b1;
      if (kind == SYM_ZERO) begin
        if (zrun_q != '1) zrun_q <= zrun_q + 1'b1;
      end else begin
        zrun_q <= '0;
      end
      if (kind == SYM_VIOL) vpos_q <= last_pos_q;
    end
  end

  AST_RAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pos_q && neg_q)); // R2
  AST_RAIL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(pos_q) && $stable(neg_q))); // R1
  AST_ZERO_RUN: assert property (@(posedge clk) disable iff (rst)
    (en && fill_q == CW'(RUN_LEN) && kind == SYM_ZERO) |-> (zrun_q < CW'(RUN_LEN - 1))); // R4
  AST_VIOL_ALT: assert property (@(posedge clk) disable iff (rst)
    (en && kind == SYM_VIOL) |-> (last_pos_q != vpos_q)); // R8
endmodule

// File: rtl/hdb3_rx_decode.sv
`timescale 1ns/1ps
// Receive side: strips substitutions and flags illegal pulse patterns.
module hdb3_rx_decode #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic lp,
  input  logic ln,
  output logic bit_q,
  output logic err_q
);
  localparam int LAST = RUN_LEN - 1;
  localparam int GW   = $clog2(RUN_LEN);
  localparam logic [GW-1:0] GAP_MIN = GW'(RUN_LEN - 2);

  logic [RUN_LEN-1:0] dbuf_q;
  logic               last_pos_q;
  logic               vpos_q;
  logic [GW-1:0]      gap_q;

  logic pulse, both, same, is_v, bad;

  always_comb begin
    pulse = lp ^ ln;
    both  = lp & ln;
    same  = pulse && (lp == last_pos_q);
    is_v  = same && (gap_q >= GAP_MIN);
    bad   = both || (same && !is_v) || (is_v && (lp == vpos_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbuf_q     <= '0;
      last_pos_q <= 1'b0;
      vpos_q     <= 1'b0;
      gap_q      <= '0;
      bit_q      <= 1'b0;
      err_q      <= 1'b0;
    end else if (en) begin
      bit_q <= dbuf_q[LAST];
      err_q <= bad;
      for (int i = 1; i < RUN_LEN; i++) dbuf_q[i] <= is_v ? 1'b0 : dbuf_q[i-1];
      dbuf_q[0] <= pulse && !is_v;
      if (pulse) last_pos_q <= lp;
      if (is_v)  vpos_q     <= lp;
      if (pulse || both)        gap_q <= '0;
      else if (gap_q < GAP_MIN) gap_q <= gap_q + 1'b1;
    end else begin
      err_q <= 1'b0;
    end
  end

  AST_BOTH_FLAG: assert property (@(posedge clk) disable iff (rst)
    (en && lp && ln) |=> err_q); // R10
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> !err_q); // R10
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(bit_q)); // R9
endmodule

// File: rtl/hdb3_line_codec.sv
`timescale 1ns/1ps
module hdb3_line_codec
  import hdb3_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  output logic pos_out,
  output logic neg_out,
  input  logic dec_en,
  input  logic dec_p,
  input  logic dec_n,
  output logic dec_bit,
  output logic dec_err
);
  sym_kind_e head_kind;

  hdb3_subst_buf #(.RUN_LEN(RUN_LEN)) u_buf (
    .clk (clk),
    .rst (rst),
    .en  (bit_en),
    .din (bit_in),
    .head(head_kind)
  );

  hdb3_pulse_drv #(.RUN_LEN(RUN_LEN)) u_drv (
    .clk  (clk),
    .rst  (rst),
    .en   (bit_en),
    .kind (head_kind),
    .pos_q(pos_out),
    .neg_q(neg_out)
  );

  hdb3_rx_decode #(.RUN_LEN(RUN_LEN)) u_dec (
    .clk  (clk),
    .rst  (rst),
    .en   (dec_en),
    .lp   (dec_p),
    .ln   (dec_n),
    .bit_q(dec_bit),
    .err_q(dec_err)
  );
endmodule

// File: tb/sim_hdb3_line_codec.sv
`timescale 1ns/1ps
module sim_hdb3_line_codec;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, bit_en, bit_in, dec_en, dec_p, dec_n;
  logic pos_out, neg_out, dec_bit, dec_err;

  hdb3_line_codec u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .pos_out(pos_out), .neg_out(neg_out),
    .dec_en(dec_en), .dec_p(dec_p), .dec_n(dec_n),
    .dec_bit(dec_bit), .dec_err(dec_err)
  );

  int checks = 0;
  int fails  = 0;

  // Scoreboard state: 0 zero, 1 one, 2 balancing pulse, 3 violation.
  int  kq[$];
  bit  dq[$];
  int  krd = 0, drd = 0;
  int  run_z;
  bit  par_m;
  bit  last_en;
  bit  mon_on = 1'b0;
  bit  mon_en, mon_den;
  bit  exp_last, v_last_act;
  logic prev_pos, prev_neg;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_bit(input bit b);
    kq.push_back(b ? 1 : 0);
    dq.push_back(b);
    if (b) begin
      par_m = ~par_m;
      run_z = 0;
    end else begin
      run_z++;
      if (run_z == 4) begin
        kq[kq.size()-1] = 3;
        if (!par_m) kq[kq.size()-4] = 2;
        par_m = 1'b0;
        run_z = 0;
      end
    end
  endtask

  task automatic step(input bit en, input bit b);
    @(negedge clk);
    dec_en  = last_en;
    dec_p   = pos_out;
    dec_n   = neg_out;
    bit_en  = en;
    bit_in  = b;
    last_en = en;
    if (en) push_bit(b);
  endtask

  always @(posedge clk) begin
    mon_en  = bit_en && !rst;
    mon_den = dec_en && !rst;
  end

  // Monitor: pops expected symbols and decoded bits as the design emits them.
  always @(negedge clk) begin
    int  k;
    bit  ep, en_;
    string tag;
    if (mon_on) begin
      if (mon_en) begin
        k = kq[krd];
        krd++;
        ep = 1'b0; en_ = 1'b0; tag = "R3";
        case (k)
          1: begin ep = ~exp_last; en_ = exp_last; exp_last = ~exp_last; tag = "R5"; end
          2: begin ep = ~exp_last; en_ = exp_last; exp_last = ~exp_last; tag = "R6"; end
          3: begin ep = exp_last;  en_ = ~exp_last; tag = "R7"; end
          default: tag = (krd > 4) ? "R4" : "R3";
        endcase
        check({pos_out, neg_out} == {ep, en_}, tag, "symbol rails",
              int'({pos_out, neg_out}), int'({ep, en_}));
        check(!(pos_out && neg_out), "R2", "rails both high", 1, 0);
        if (k == 3 && (pos_out ^ neg_out)) begin
          check(pos_out != v_last_act, "R8", "violation polarity repeat",
                int'(pos_out), int'(~v_last_act));
          v_last_act = pos_out;
        end
      end else begin
        check(pos_out == prev_pos && neg_out == prev_neg, "R1", "rails changed without enable",
              int'({pos_out, neg_out}), int'({prev_pos, prev_neg}));
      end
      if (mon_den) begin
        check(dec_bit == dq[drd], "R9", "loopback bit", int'(dec_bit), int'(dq[drd]));
        drd++;
        check(!dec_err, "R10", "error on valid line", int'(dec_err), 0);
      end
      prev_pos = pos_out;
      prev_neg = neg_out;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // Receive-side injection: rails, expected error and decoded symbol.
  localparam logic [18:0] INJ_P = 19'h00065;
  localparam logic [18:0] INJ_N = 19'h048C0;
  localparam logic [18:0] INJ_E = 19'h04044;
  localparam logic [18:0] INJ_D = 19'h00081;

  initial begin
    logic [15:0] lf;
    rst = 1'b1; bit_en = 1'b0; bit_in = 1'b0;
    dec_en = 1'b0; dec_p = 1'b0; dec_n = 1'b0; last_en = 1'b0;
    repeat (3) @(negedge clk);
    // R11: outputs low while reset is held
    check(pos_out == 0, "R11", "pos_out in reset", int'(pos_out), 0);
    check(neg_out == 0, "R11", "neg_out in reset", int'(neg_out), 0);
    check(dec_bit == 0, "R11", "dec_bit in reset", int'(dec_bit), 0);
    check(dec_err == 0, "R11", "dec_err in reset", int'(dec_err), 0);
    rst = 1'b0;
    kq = '{0, 0, 0, 0};
    for (int i = 0; i < 8; i++) dq.push_back(1'b0);
    run_z = 3; par_m = 1'b0; exp_last = 1'b0; v_last_act = 1'b0;
    prev_pos = 1'b0; prev_neg = 1'b0;
    mon_on = 1'b1;

    // Leading zeros: substitution straight out of reset (R6)
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
    // One pulse then a run: odd count gives 000V (R7)
    step(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    // Two pulses then a run: even count gives B00V (R6)
    step(1'b1, 1'b1); step(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    // Three pulses, run, with enable gaps (R1)
    for (int i = 0; i < 3; i++) begin step(1'b1, 1'b1); step(1'b0, 1'b0); end
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    // All ones (R5)
    for (int i = 0; i < 9; i++) step(1'b1, 1'b1);
    // Back-to-back runs (R4, R8)
    for (int i = 0; i < 13; i++) step(1'b1, 1'b0);
    // Pseudo-random traffic with gaps
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      step((i % 7) != 6, lf[0] & lf[3]);
      lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
    end
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    @(negedge clk);
    mon_on = 1'b0;
    check(drd > 400, "R9", "decoded bit count", drd, 401);

    // Receive-side error checks
    rst = 1'b1;
    bit_en = 1'b0; dec_en = 1'b0; dec_p = 1'b0; dec_n = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 19; i++) begin
      @(negedge clk);
      dec_en = 1'b1; dec_p = INJ_P[i]; dec_n = INJ_N[i];
      @(negedge clk);
      dec_en = 1'b0; dec_p = 1'b0; dec_n = 1'b0;
      check(dec_err == INJ_E[i], "R10", $sformatf("error flag step %0d", i),
            int'(dec_err), int'(INJ_E[i]));
      check(dec_bit == ((i < 4) ? 1'b0 : INJ_D[i-4]), "R9",
            $sformatf("decoded bit step %0d", i),
            int'(dec_bit), int'((i < 4) ? 1'b0 : INJ_D[i-4]));
    end
    @(negedge clk);
    check(dec_err == 0, "R10", "error clears without enable", int'(dec_err), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule